// File: doc/BRIEF.md
# Grouped Consecutive-Cycle Alarm Filter

This block qualifies raw fault flags from analog detectors before any status logic may use them. Each raw flag has its own run counter. The counter advances on every falling edge of the filter clock at which the flag is high. The flag is reported as accepted once its run of consecutive high samples reaches the required length N. A single low sample ends the run at once and withdraws the acceptance.

The alarms fall into two classes, and each class takes its own threshold from one configuration byte. The lower nibble sets N for the lead-off class. The upper nibble sets N for the range class, which covers amplifier out-of-range, modulator over-range, common-mode out-of-range, drive-near-rail and low-supply flags. A nibble value v gives N = v + 1, so N spans 1 to 16. The filter clock is a slow oscillator-derived clock. All state moves on its falling edge, so nothing can be accepted while that clock is stopped. Latching, clear-on-read and interrupt generation belong to the consumer of the outputs.

Top module: `alarm_qual_filter`

## Requirements
- R1: With threshold field v (N = v + 1), an output bit first reads 1 after the Nth consecutive falling edge that sampled its raw input high, and reads 0 after every earlier edge of that run.
- R2: Field value 0 accepts on the first falling edge that samples the raw input high. Field value 15 needs 16 such edges, so the output is still 0 after 15 of them.
- R3: cfg_i[3:0] sets the threshold of every lead-off bit only, and cfg_i[7:4] sets the threshold of every range bit only.
- R4: Once accepted, an output stays 1 for as long as its raw input is sampled high, including runs far longer than 16 edges.
- R5: At the first falling edge that samples the raw input low, the output goes to 0 and the run restarts from zero. A new run then needs the full N edges again.
- R6: While rst_ni is sampled low at a falling edge, all run counters and all outputs clear at that edge (synchronous, active low).
- R7: State changes only on falling edges of clk_i. With the clock stopped, an output does not rise, however long its raw input is held high.
- R8: Each alarm bit is filtered independently. A raw input affects no output bit other than its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Filter clock; logic advances on its falling edge |
| rst_ni | input | 1 | Synchronous active-low reset |
| cfg_i | input | 8 | [3:0] lead-off threshold field, [7:4] range threshold field |
| lod_raw_i | input | N_LOD | Raw lead-off alarm flags |
| rng_raw_i | input | N_RNG | Raw range-class alarm flags |
| lod_ok_o | output | N_LOD | Qualified lead-off alarms |
| rng_ok_o | output | N_RNG | Qualified range-class alarms |

## Verification
A run counter that is one count off shows up as an output rising one filter edge early or late. That step is visible in the first run that reaches the threshold. A counter that fails to clear on a low sample lets the next run be accepted too soon, so the bench drives single-edge dropouts followed by fresh runs. A swapped nibble or a counter that wraps instead of saturating shows only with unequal thresholds in the two classes, or with runs longer than 16 edges. Each of these cases is driven directly. The outputs are also compared on every cycle against a reference model under random stimulus.

// File: rtl/alarm_filt_pkg.sv
// Shared constants, types and helpers for the alarm qualification filter.
// Assumes a threshold field of THR_W bits encoding N = field + 1.
package alarm_filt_pkg;
    localparam int unsigned THR_W   = 4;
    localparam int unsigned RUN_W   = THR_W + 1;
    localparam int unsigned RUN_MAX = 2 ** THR_W;

    typedef logic [THR_W-1:0] thr_t;
    typedef logic [RUN_W-1:0] run_t;

    // True once a run of 'run' high samples meets threshold field 'thr' (N = thr + 1).
    function automatic logic run_reached(run_t run, thr_t thr);
        return run > run_t'(thr);
    endfunction
endpackage

// File: rtl/alarm_run_cell.sv
// One alarm qualifier: counts consecutive falling-edge samples of raw_i high,
// saturating at RUN_MAX, and raises q_o once the run meets thr_i + 1.
// Assumes thr_i is quasi-static relative to the filter clock.
module alarm_run_cell
    import alarm_filt_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic raw_i,
    input  thr_t thr_i,
    output logic q_o
);
    run_t run_q;
    run_t run_nx;

    // Next run length: restart on low, count up on high, hold at the ceiling.
    always_comb begin
        if (!raw_i) begin
            run_nx = '0;
        end else if (run_q == run_t'(RUN_MAX)) begin
            run_nx = run_q;
        end else begin
            run_nx = run_q + run_t'(1);
        end
    end

    // Register run length and qualified flag on the filter clock's falling edge.
    always_ff @(negedge clk_i) begin
        if (!rst_ni) begin
            run_q <= '0;
            q_o   <= 1'b0;
        end else begin
            run_q <= run_nx;
            q_o   <= raw_i && run_reached(run_nx, thr_i);
        end
    end

    AST_DROP_ON_LOW: assert property (@(negedge clk_i) disable iff (!rst_ni)
        !raw_i |=> !q_o);  // R5
    AST_HOLD_WHILE_HIGH: assert property (@(negedge clk_i) disable iff (!rst_ni)
        (q_o && raw_i && $stable(thr_i)) |=> q_o);  // R4
    AST_NO_EARLY_ACCEPT: assert property (@(negedge clk_i) disable iff (!rst_ni)
        ($rose(raw_i) && thr_i != '0) |=> !q_o);  // R1
    AST_RUN_CEILING: assert property (@(negedge clk_i) disable iff (!rst_ni)
        run_q <= run_t'(RUN_MAX));  // R2
endmodule

// File: rtl/alarm_group.sv
// A class of WIDTH alarm qualifiers that share one threshold field.
// Assumes every member of the class uses the same consecutive-sample count.
module alarm_group
    import alarm_filt_pkg::*;
#(
    parameter int unsigned WIDTH = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  thr_t             thr_i,
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] ok_o
);
    // One independent qualifier per alarm bit.
    for (genvar g = 0; g < WIDTH; g++) begin : g_cell
        alarm_run_cell u_cell (
            .clk_i (clk_i),
            .rst_ni(rst_ni),
            .raw_i (raw_i[g]),
            .thr_i (thr_i),
            .q_o   (ok_o[g])
        );
    end

    AST_GROUP_RESET: assert property (@(negedge clk_i)
        !rst_ni |=> ok_o == '0);  // R6
endmodule

// File: rtl/alarm_qual_filter.sv
// Top of the alarm filter: splits the configuration byte into two threshold
// fields, low nibble for the lead-off class and high nibble for the range class.
// Assumes all logic runs on the falling edge of the slow filter clock.
module alarm_qual_filter
    import alarm_filt_pkg::*;
#(
    parameter int unsigned N_LOD = 4,
    parameter int unsigned N_RNG = 12
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [2*THR_W-1:0] cfg_i,
    input  logic [N_LOD-1:0]   lod_raw_i,
    input  logic [N_RNG-1:0]   rng_raw_i,
    output logic [N_LOD-1:0]   lod_ok_o,
    output logic [N_RNG-1:0]   rng_ok_o
);
    thr_t lod_thr;
    thr_t rng_thr;

    // Field split: low nibble to lead-off, high nibble to range class.
    always_comb begin
        lod_thr = cfg_i[THR_W-1:0];
        rng_thr = cfg_i[2*THR_W-1:THR_W];
    end

    alarm_group #(.WIDTH(N_LOD)) u_lod (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .thr_i (lod_thr),
        .raw_i (lod_raw_i),
        .ok_o  (lod_ok_o)
    );

    alarm_group #(.WIDTH(N_RNG)) u_rng (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .thr_i (rng_thr),
        .raw_i (rng_raw_i),
        .ok_o  (rng_ok_o)
    );

    AST_OK_NEEDS_RAW: assert property (@(negedge clk_i) disable iff (!rst_ni)
        (lod_ok_o & ~$past(lod_raw_i)) == '0);  // R8
endmodule

// File: tb/tb_alarm_qual_filter.sv
module tb_alarm_qual_filter;
    localparam int NL = 4;
    localparam int NR = 12;

    logic          clk = 1'b0;
    logic          clk_en = 1'b1;
    logic          rst_n = 1'b0;
    logic [7:0]    cfg = 8'h00;
    logic [NL-1:0] lod_raw = '0;
    logic [NR-1:0] rng_raw = '0;
    logic [NL-1:0] lod_ok;
    logic [NR-1:0] rng_ok;

    int n_chk = 0;
    int n_bad = 0;
    int k_lod [NL];
    int k_rng [NR];
    logic [NL-1:0] exp_lod = '0;
    logic [NR-1:0] exp_rng = '0;

    alarm_qual_filter #(.N_LOD(NL), .N_RNG(NR)) dut (
        .clk_i(clk), .rst_ni(rst_n), .cfg_i(cfg),
        .lod_raw_i(lod_raw), .rng_raw_i(rng_raw),
        .lod_ok_o(lod_ok), .rng_ok_o(rng_ok)
    );

    // 250 MHz clock that can be paused in its high phase.
    initial forever begin
        #2;
        if (clk_en) clk = ~clk;
    end

    function automatic int next_run(int k, logic raw);
        if (!raw) return 0;
        return (k >= 16) ? 16 : k + 1;
    endfunction

    function automatic logic accepted(int k, logic [3:0] field);
        return k >= int'(field) + 1;
    endfunction

    // Reference model, updated on each falling edge.
    always @(negedge clk) begin
        for (int i = 0; i < NL; i++) begin
            k_lod[i]   = rst_n ? next_run(k_lod[i], lod_raw[i]) : 0;
            exp_lod[i] = accepted(k_lod[i], cfg[3:0]);
        end
        for (int i = 0; i < NR; i++) begin
            k_rng[i]   = rst_n ? next_run(k_rng[i], rng_raw[i]) : 0;
            exp_rng[i] = accepted(k_rng[i], cfg[7:4]);
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Advance one cycle and compare against the model.
    task automatic step();
        @(posedge clk);
        #1;
        chk("R1/R4/R5 model lod", 32'(lod_ok), 32'(exp_lod));
        chk("R1/R4/R5 model rng", 32'(rng_ok), 32'(exp_rng));
    endtask

    task automatic steps(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'd2024);
        steps(3);
        chk("R6 reset lod", 32'(lod_ok), 32'd0);
        chk("R6 reset rng", 32'(rng_ok), 32'd0);
        rst_n = 1'b1;

        // R2/R3: lead-off N=1, range N=4
        cfg = 8'h30;
        lod_raw = 4'b0001; rng_raw = 12'h001;
        step();
        chk("R2 N=1 accepts first edge", 32'(lod_ok), 32'h1);
        chk("R3 range not yet", 32'(rng_ok), 32'h0);
        steps(2);
        chk("R1 range still low after 3", 32'(rng_ok), 32'h0);
        step();
        chk("R1 range accepted after 4", 32'(rng_ok), 32'h1);

        // R5: single-edge dropout restarts the run
        lod_raw = '0; rng_raw = '0;
        step();
        chk("R5 lod drops", 32'(lod_ok), 32'h0);
        chk("R5 rng drops", 32'(rng_ok), 32'h0);
        rng_raw = 12'h001;
        steps(3);
        chk("R5 restart needs full N", 32'(rng_ok), 32'h0);
        step();
        chk("R5 restart accepted", 32'(rng_ok), 32'h1);

        // R2/R4: N=16 on range, long run
        rng_raw = '0; step();
        cfg = 8'hF0;
        rng_raw = 12'h800;
        steps(15);
        chk("R2 N=16 low after 15", 32'(rng_ok), 32'h0);
        step();
        chk("R2 N=16 high after 16", 32'(rng_ok), 32'h800);
        steps(30);
        chk("R4 holds past 16", 32'(rng_ok), 32'h800);

        // R8/R3: one lead-off bit, swapped fields
        rng_raw = '0; cfg = 8'h0F; lod_raw = 4'b0010;
        step();
        chk("R3 low nibble governs lod", 32'(lod_ok), 32'h0);
        steps(15);
        chk("R8 only own bit", 32'(lod_ok), 32'h2);
        chk("R8 range untouched", 32'(rng_ok), 32'h0);

        // R7: stopped clock accepts nothing
        lod_raw = '0; step();
        cfg = 8'h00;
        @(posedge clk); #1;
        clk_en = 1'b0;
        lod_raw = 4'b0100;
        #40;
        chk("R7 no accept while stopped", 32'(lod_ok), 32'h0);
        clk_en = 1'b1;
        step();
        chk("R7 accepts after an edge", 32'(lod_ok), 32'h4);

        // R6: reset in mid-run
        rst_n = 1'b0;
        step();
        chk("R6 mid-run reset", 32'(lod_ok), 32'h0);
        rst_n = 1'b1;
        step();
        chk("R6 restart after reset", 32'(lod_ok), 32'h4);

        // Random stimulus with sticky inputs
        for (int c = 0; c < 2000; c++) begin
            for (int i = 0; i < NL; i++) if ($urandom_range(7) == 0) lod_raw[i] = ~lod_raw[i];
            for (int i = 0; i < NR; i++) if ($urandom_range(7) == 0) rng_raw[i] = ~rng_raw[i];
            if ($urandom_range(63) == 0) cfg = 8'($urandom);
            rst_n = ($urandom_range(299) != 0);
            step();
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule